// File: doc/BRIEF.md
# Serial-Access Transceiver Tuning Port

This block sits on a simple 32-bit register bus and gives software a narrow path into the tuning bits of up to three USB transceivers. Software cannot reach those bits directly. Instead it composes a control word that holds an 8-bit internal bit address and a single data bit, then raises the strobe bit that belongs to one transceiver. Each rising strobe edge copies the data bit into that transceiver's tuning storage at the selected address. A multi-bit field is built by repeating this with the address stepped up by one per bit, least significant bit first.

The window holds four word registers. Byte offset 0x00 is interface status/control, 0x04 is the serial control word, 0x08 is built-in self-test storage and 0x0C is tune storage. All four read back what was last written into them. Tuning bits are kept per transceiver in a window of twelve internal addresses. Two further addresses hold bits that all transceivers share. The decoded fields are driven straight out as ports.

Top module: `usbtune_port`

## Requirements
- R1: On reset every register reads zero, and every tuning field and shared bit output is zero.
- R2: The register at byte offset 0x00, 0x04, 0x08 or 0x0C (selected by `bus_addr_i[3:2]`) returns on `bus_rdata_o` the value most recently written into it.
- R3: A write updates only the byte lanes whose `bus_be_i` bit is set. A write to the control word with `bus_be_i = 4'b0001` leaves bits 31:8, including the address field, unchanged.
- R4: In the control word, bits 15:8 are the internal bit address, bit 7 is the data bit, and bit 2*n is the strobe of transceiver n. A bus write that sets the strobe is registered at one rising clock edge. The tuning output changes at the next rising edge, not earlier.
- R5: A strobe that is held high writes only once. While it stays high, later changes to the data bit or the address have no effect.
- R6: A strobe edge of transceiver n changes no tuning output of any other transceiver.
- R7: Per-transceiver field map, with the least significant bit at the lowest address. TX amplitude is 0x20–0x21. Slew rate is 0x22–0x24, so a five-bit load starting at 0x20 covers both amplitude and slew. VBUS-valid threshold is 0x25–0x26. Pull-up select is 0x27. OTG function enable is 0x28. VBUS detect enable is 0x29. Disconnect threshold is 0x2A–0x2B.
- R8: Address 0x03 (PLL bandwidth) and address 0x0C (resistor calibration enable) are single bits shared by all transceivers. A strobe edge of any transceiver writes them.
- R9: A strobe edge at an address that is neither in the window 0x20–0x2B nor one of the shared addresses changes no output.
- R10: A falling strobe edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 4 | Byte address; bits 3:2 select the register |
| bus_be_i | input | 4 | Byte-lane enables for a write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| tx_amp_o | output | 2*NUM_XCVR | TX amplitude field per transceiver |
| tx_slew_o | output | 3*NUM_XCVR | Slew-rate field per transceiver |
| vbus_th_o | output | 2*NUM_XCVR | VBUS-valid threshold per transceiver |
| pullup_sel_o | output | NUM_XCVR | Pull-up select per transceiver |
| otg_en_o | output | NUM_XCVR | OTG function enable per transceiver |
| vbus_det_en_o | output | NUM_XCVR | VBUS detect enable per transceiver |
| disc_th_o | output | 2*NUM_XCVR | Disconnect threshold per transceiver |
| pll_bw_o | output | 1 | Shared PLL bandwidth bit |
| rescal_en_o | output | 1 | Shared resistor calibration enable |

## Verification
If a strobe-history flop is stuck or cleared, a held strobe writes again on a later data change, or a write is lost altogether. Either shows on a field output two clock edges after the offending bus write. A wrong window offset or address decode puts a bit into a neighbouring field or into another transceiver, and the field outputs show this right after the strobe edge. A register lane that is enabled wrongly corrupts the address field. The fault then shows as a misplaced tuning bit on the next strobe, or at once when the register is read back.

// File: rtl/usbtune_pkg.sv
package usbtune_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_REGS = 4;
    localparam int RIDX_W   = $clog2(NUM_REGS);
    localparam int LANES    = REG_W / 8;

    localparam logic [RIDX_W-1:0] RIDX_IFC  = 2'd0;
    localparam logic [RIDX_W-1:0] RIDX_CTL  = 2'd1;
    localparam logic [RIDX_W-1:0] RIDX_BIST = 2'd2;
    localparam logic [RIDX_W-1:0] RIDX_TUNE = 2'd3;

    // control word layout
    localparam int BADDR_LSB = 8;
    localparam int BADDR_W   = 8;
    localparam int BDATA_POS = 7;

    // per-transceiver tuning window
    localparam logic [7:0] WIN_BASE = 8'h20;
    localparam int         WIN_LEN  = 12;

    localparam int AMP_OFS  = 0;  localparam int AMP_W  = 2;
    localparam int SLEW_OFS = 2;  localparam int SLEW_W = 3;
    localparam int VTH_OFS  = 5;  localparam int VTH_W  = 2;
    localparam int PULL_OFS = 7;
    localparam int OTG_OFS  = 8;
    localparam int VDET_OFS = 9;
    localparam int DISC_OFS = 10; localparam int DISC_W = 2;

    // shared bits
    localparam int NUM_CMN = 2;
    localparam int CMN_PLL = 0;
    localparam int CMN_CAL = 1;

    function automatic logic [7:0] cmn_addr(input int k);
        return (k == CMN_PLL) ? 8'h03 : 8'h0C;
    endfunction

    typedef logic [NUM_REGS-1:0][REG_W-1:0] regfile_t;
endpackage

// File: rtl/usbtune_regs.sv
module usbtune_regs
    import usbtune_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [RIDX_W-1:0]    idx_i,
    input  logic [LANES-1:0]     be_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     rdata_o,
    output logic [REG_W-1:0]     ctl_o
);
    typedef struct packed {
        regfile_t r;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            for (int b = 0; b < LANES; b++) begin
                if (be_i[b]) begin
                    s_d.r[idx_i][8*b +: 8] = wdata_i[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rdata_o = s_q.r[idx_i];
    assign ctl_o   = s_q.r[RIDX_CTL];
endmodule

// File: rtl/usbtune_xcvr.sv
module usbtune_xcvr
    import usbtune_pkg::*;
#(
    parameter logic [7:0] BASE = WIN_BASE,
    parameter int         LEN  = WIN_LEN,
    parameter int         NCMN = NUM_CMN
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            strb_i,
    input  logic [7:0]      baddr_i,
    input  logic            bdata_i,
    output logic [LEN-1:0]  win_o,
    output logic [NCMN-1:0] cmn_we_o
);
    localparam int IDX_W = $clog2(LEN);

    typedef struct packed {
        logic           prev;
        logic [LEN-1:0] win;
    } state_t;

    state_t s_d, s_q;
    logic       rise;
    logic [7:0] off;
    logic       in_win;

    assign rise   = strb_i & ~s_q.prev;
    assign off    = baddr_i - BASE;
    assign in_win = (baddr_i >= BASE) && (off < 8'(LEN));

    always_comb begin
        s_d      = s_q;
        s_d.prev = strb_i;
        if (rise && in_win) begin
            s_d.win[IDX_W'(off)] = bdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar k = 0; k < NCMN; k++) begin : g_cmn
        assign cmn_we_o[k] = rise && (baddr_i == cmn_addr(k));
    end

    assign win_o = s_q.win;
endmodule

// File: rtl/usbtune_common.sv
module usbtune_common
    import usbtune_pkg::*;
#(
    parameter int NX   = 3,
    parameter int NCMN = NUM_CMN
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NX-1:0][NCMN-1:0]   we_i,
    input  logic                      bdata_i,
    output logic [NCMN-1:0]           cmn_o
);
    typedef struct packed {
        logic [NCMN-1:0] bits;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NCMN; k++) begin
            for (int x = 0; x < NX; x++) begin
                if (we_i[x][k]) s_d.bits[k] = bdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cmn_o = s_q.bits;
endmodule

// File: rtl/usbtune_port.sv
module usbtune_port
    import usbtune_pkg::*;
#(
    parameter int NUM_XCVR = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       bus_wr_i,
    input  logic [3:0]                 bus_addr_i,
    input  logic [3:0]                 bus_be_i,
    input  logic [31:0]                bus_wdata_i,
    output logic [31:0]                bus_rdata_o,
    output logic [AMP_W*NUM_XCVR-1:0]  tx_amp_o,
    output logic [SLEW_W*NUM_XCVR-1:0] tx_slew_o,
    output logic [VTH_W*NUM_XCVR-1:0]  vbus_th_o,
    output logic [NUM_XCVR-1:0]        pullup_sel_o,
    output logic [NUM_XCVR-1:0]        otg_en_o,
    output logic [NUM_XCVR-1:0]        vbus_det_en_o,
    output logic [DISC_W*NUM_XCVR-1:0] disc_th_o,
    output logic                       pll_bw_o,
    output logic                       rescal_en_o
);
    logic [REG_W-1:0]                       ctl_word;
    logic [BADDR_W-1:0]                     baddr;
    logic                                   bdata;
    logic [NUM_XCVR-1:0][WIN_LEN-1:0]       win_all;
    logic [NUM_XCVR-1:0][NUM_CMN-1:0]       cmn_we;
    logic [NUM_CMN-1:0]                     cmn_bits;

    usbtune_regs i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .idx_i   (bus_addr_i[3:2]),
        .be_i    (bus_be_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .ctl_o   (ctl_word)
    );

    assign baddr = ctl_word[BADDR_LSB +: BADDR_W];
    assign bdata = ctl_word[BDATA_POS];

    for (genvar x = 0; x < NUM_XCVR; x++) begin : g_xcvr
        usbtune_xcvr #(
            .BASE (WIN_BASE),
            .LEN  (WIN_LEN),
            .NCMN (NUM_CMN)
        ) i_xcvr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .strb_i   (ctl_word[2*x]),
            .baddr_i  (baddr),
            .bdata_i  (bdata),
            .win_o    (win_all[x]),
            .cmn_we_o (cmn_we[x])
        );

        assign tx_amp_o[AMP_W*x +: AMP_W]    = win_all[x][AMP_OFS +: AMP_W];
        assign tx_slew_o[SLEW_W*x +: SLEW_W] = win_all[x][SLEW_OFS +: SLEW_W];
        assign vbus_th_o[VTH_W*x +: VTH_W]   = win_all[x][VTH_OFS +: VTH_W];
        assign pullup_sel_o[x]               = win_all[x][PULL_OFS];
        assign otg_en_o[x]                   = win_all[x][OTG_OFS];
        assign vbus_det_en_o[x]              = win_all[x][VDET_OFS];
        assign disc_th_o[DISC_W*x +: DISC_W] = win_all[x][DISC_OFS +: DISC_W];
    end

    usbtune_common #(
        .NX   (NUM_XCVR),
        .NCMN (NUM_CMN)
    ) i_common (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cmn_we),
        .bdata_i (bdata),
        .cmn_o   (cmn_bits)
    );

    assign pll_bw_o    = cmn_bits[CMN_PLL];
    assign rescal_en_o = cmn_bits[CMN_CAL];
endmodule

// File: rtl/usbtune_port_chk.sv
module usbtune_port_chk
    import usbtune_pkg::*;
#(
    parameter int NUM_XCVR = 3
) (
    input logic                              clk_i,
    input logic                              rst_ni,
    input logic                              bus_wr_i,
    input logic [3:0]                        bus_addr_i,
    input logic [3:0]                        bus_be_i,
    input logic [REG_W-1:0]                  ctl_q,
    input logic [NUM_XCVR-1:0][WIN_LEN-1:0]  win,
    input logic [NUM_CMN-1:0]                cmn
);
    localparam int IDX_W = $clog2(WIN_LEN);

    logic [7:0]          ba;
    logic [7:0]          ofs;
    logic [IDX_W-1:0]    ofs_s;
    logic                ba_in_win;
    logic [NUM_XCVR-1:0] strb, strb_prev;
    logic                any_rise;

    assign ba        = ctl_q[BADDR_LSB +: BADDR_W];
    assign ofs       = ba - WIN_BASE;
    assign ofs_s     = ofs[IDX_W-1:0];
    assign ba_in_win = (ba >= WIN_BASE) && (ofs < 8'(WIN_LEN));

    for (genvar x = 0; x < NUM_XCVR; x++) begin : g_strb
        assign strb[x] = ctl_q[2*x];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) strb_prev <= '0;
        else         strb_prev <= strb;
    end
    assign any_rise = |(strb & ~strb_prev);

    for (genvar x = 0; x < NUM_XCVR; x++) begin : g_ast
        AST_HELD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$rose(strb[x]) |=> $stable(win[x])); // R5
        AST_BIT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($rose(strb[x]) && ba_in_win) |=> (win[x][$past(ofs_s)] == $past(ctl_q[BDATA_POS]))); // R4
        AST_OUTSIDE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($rose(strb[x]) && !ba_in_win) |=> $stable(win[x])); // R9
    end

    AST_CMN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_rise |=> $stable(cmn)); // R8

    AST_LOW_BYTE_KEEPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i[3:2] == RIDX_CTL && bus_be_i == 4'b0001)
        |=> (ctl_q[31:8] == $past(ctl_q[31:8]))); // R3
endmodule

bind usbtune_port usbtune_port_chk #(.NUM_XCVR(NUM_XCVR)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_be_i   (bus_be_i),
    .ctl_q      (ctl_word),
    .win        (win_all),
    .cmn        (cmn_bits)
);

// File: tb/test_usbtune_port.sv
`timescale 1ns/1ps
module test_usbtune_port;
    localparam int NX = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2*NX-1:0] amp, vth, disc;
    logic [3*NX-1:0] slew;
    logic [NX-1:0]   pull, otg, vdet;
    logic            pll, cal;

    int checks = 0;
    int errors = 0;

    logic [11:0] m_win [NX];
    logic [1:0]  m_cmn;

    always #4 clk = ~clk;

    usbtune_port #(.NUM_XCVR(NX)) i_usbtune_port (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tx_amp_o(amp), .tx_slew_o(slew), .vbus_th_o(vth),
        .pullup_sel_o(pull), .otg_en_o(otg), .vbus_det_en_o(vdet),
        .disc_th_o(disc), .pll_bw_o(pll), .rescal_en_o(cal)
    );

    // {xcvr[1:0], bit address[7:0], data}
    localparam logic [10:0] VEC [16] = '{
        {2'd1, 8'h20, 1'b0}, {2'd1, 8'h21, 1'b0}, {2'd1, 8'h22, 1'b1},
        {2'd1, 8'h23, 1'b0}, {2'd1, 8'h24, 1'b1},
        {2'd0, 8'h2A, 1'b1}, {2'd0, 8'h2B, 1'b0},
        {2'd2, 8'h25, 1'b1}, {2'd2, 8'h26, 1'b1}, {2'd2, 8'h27, 1'b1},
        {2'd2, 8'h28, 1'b1}, {2'd2, 8'h29, 1'b1},
        {2'd2, 8'h03, 1'b1}, {2'd0, 8'h0C, 1'b1}, {2'd1, 8'h03, 1'b0},
        {2'd0, 8'h20, 1'b1}
    };

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr = 1'b0; be = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic write_bit(input int xc, input logic [7:0] ba, input logic dat);
        logic [6:0] sb;
        sb = 7'(1 << (2 * xc));
        bus_write(4'h4, 4'hF, {16'h0, ba, dat, 7'h0});
        bus_write(4'h4, 4'h1, {24'h0, dat, sb});
        bus_write(4'h4, 4'h1, {24'h0, dat, 7'h0});
    endtask

    task automatic model_bit(input int xc, input logic [7:0] ba, input logic dat);
        if (ba >= 8'h20 && ba < 8'h2C) m_win[xc][4'(ba - 8'h20)] = dat;
        else if (ba == 8'h03)          m_cmn[0] = dat;
        else if (ba == 8'h0C)          m_cmn[1] = dat;
    endtask

    task automatic check_all(input string req);
        for (int x = 0; x < NX; x++) begin
            check_eq(req, 32'({disc[2*x +: 2], vdet[x], otg[x], pull[x],
                               vth[2*x +: 2], slew[3*x +: 3], amp[2*x +: 2]}),
                     32'(m_win[x]));
        end
        check_eq(req, 32'({cal, pll}), 32'(m_cmn));
    endtask

    task automatic clear_model();
        for (int x = 0; x < NX; x++) m_win[x] = '0;
        m_cmn = '0;
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1 reset fields");
        for (int r = 0; r < 4; r++) begin
            bus_read(4'(r * 4), rd);
            check_eq("R1 reset regs", rd, 32'h0);
        end

        // R2: readback of all four registers
        bus_write(4'h0, 4'hF, 32'h1234_5678);
        bus_write(4'h4, 4'hF, 32'h5A5A_0000);
        bus_write(4'h8, 4'hF, 32'hDEAD_BEEF);
        bus_write(4'hC, 4'hF, 32'hCAFE_F00D);
        bus_read(4'h0, rd); check_eq("R2 ifc", rd, 32'h1234_5678);
        bus_read(4'h4, rd); check_eq("R2 ctl", rd, 32'h5A5A_0000);
        bus_read(4'h8, rd); check_eq("R2 bist", rd, 32'hDEAD_BEEF);
        bus_read(4'hC, rd); check_eq("R2 tune", rd, 32'hCAFE_F00D);

        // R3: byte lanes
        bus_write(4'h4, 4'b0001, 32'hFFFF_FF42);
        bus_read(4'h4, rd); check_eq("R3 low byte", rd, 32'h5A5A_0042);
        bus_write(4'h4, 4'b0100, 32'h0077_0000);
        bus_read(4'h4, rd); check_eq("R3 lane2", rd, 32'h5A77_0042);
        bus_write(4'h4, 4'hF, 32'h0);
        check_all("R3 no tuning effect");

        // R7 R6 R8: vector table
        foreach (VEC[i]) begin
            write_bit(int'(VEC[i][10:9]), VEC[i][8:1], VEC[i][0]);
            model_bit(int'(VEC[i][10:9]), VEC[i][8:1], VEC[i][0]);
            check_all("R7/R6/R8 vector");
        end
        check_eq("R7 slew of xcvr1", 32'(slew[5:3]), 32'h5);
        check_eq("R8 shared pll", 32'(pll), 32'h0);
        check_eq("R8 shared cal", 32'(cal), 32'h1);

        // R4: timing of a strobe write (xcvr0, addr 0x29, data 1)
        bus_write(4'h4, 4'hF, {16'h0, 8'h29, 8'h80});
        bus_write(4'h4, 4'h1, 32'h81);
        check_eq("R4 not before second edge", 32'(vdet[0]), 32'h0);
        @(negedge clk);
        check_eq("R4 after second edge", 32'(vdet[0]), 32'h1);
        model_bit(0, 8'h29, 1'b1);

        // R5: held-high strobe, then change data and address
        bus_write(4'h4, 4'h1, 32'h01);
        bus_write(4'h4, 4'h2, 32'h0000_2800);
        repeat (2) @(negedge clk);
        check_all("R5 held strobe");
        // R10: falling edge writes nothing
        bus_write(4'h4, 4'h1, 32'h80);
        repeat (2) @(negedge clk);
        check_all("R10 falling edge");

        // R9: outside addresses
        write_bit(1, 8'h40, 1'b1);
        write_bit(1, 8'h1F, 1'b1);
        write_bit(2, 8'h2C, 1'b1);
        check_all("R9 outside window");

        // R1: reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        clear_model();
        check_all("R1 second reset");
        bus_read(4'hC, rd); check_eq("R1 second reset tune", rd, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule